// File: doc/BRIEF.md
# Register-Window Write Target with Single-Word Disconnect

This block sits on a 32-bit multiplexed address/data bus of the PCI kind and acts as a target for writes into a small window of operation registers. It watches for the address phase of a new transaction and claims it only when the command is a memory write or an I/O write and the address lands inside its window. When it claims a transaction it asserts its device-select, ready and stop outputs together in the cycle after the address phase. Exactly one data word is accepted with zero wait states, and the initiator is disconnected from any further data phases.

One word slot in the window feeds an inbound FIFO rather than a register. If that FIFO is full when a write to it is decoded, the block claims the cycle and asserts stop without ready. No data moves, and the initiator is told to retry later. Every accepted word appears as a one-cycle register write strobe or a FIFO push, with the word index, the data and active-high byte enables.

Top module: `optreg_wr_target`

## Requirements
- R1: While reset is high, and in the first cycle after it, devsel_n, trdy_n and stop_n are 1, and reg_wr_en and fifo_push are 0.
- R2: A transaction is claimed only when cbe_n in the address phase is 4'b0111 (memory write) or 4'b0011 (I/O write) and BASE <= ad < BASE + 4*REG_COUNT. Any other command or address leaves devsel_n, trdy_n and stop_n at 1 for the whole transaction.
- R3: In the cycle right after a claimed address phase, devsel_n and stop_n are 0. trdy_n is also 0 in that cycle unless R7 applies.
- R4: While irdy_n is 1, a claimed transaction holds trdy_n at 0 and raises no strobe. The word is taken only in a cycle where irdy_n and trdy_n are both 0.
- R5: For a word index ((ad - BASE) >> 2) other than FIFO_IDX (default 3), the transfer cycle raises reg_wr_en for that cycle. In that cycle reg_wr_addr is the index, reg_wr_data is ad, and reg_wr_be is ~cbe_n (bit k of reg_wr_be enables byte k).
- R6: For word index FIFO_IDX, the transfer cycle raises fifo_push with fifo_data equal to ad, and reg_wr_en stays 0.
- R7: When fifo_full is 1 in the address phase of a claimed write to index FIFO_IDX, devsel_n and stop_n go to 0 and trdy_n stays 1 for the whole transaction. Neither fifo_push nor reg_wr_en is raised.
- R8: After the single transfer, trdy_n returns to 1 and stop_n stays 0. No further strobe is raised, even while the initiator holds frame_n and irdy_n at 0 to attempt a burst.
- R9: In the cycle after one in which frame_n and irdy_n are both 1, devsel_n and stop_n are 1 again. An address phase in that same following cycle is decoded.
- R10: Only the first cycle with frame_n at 0 after a cycle with frame_n and irdy_n both at 1 counts as an address phase. A matching pattern in a later cycle of another transaction is not claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad | input | 32 | Multiplexed address/data |
| cbe_n | input | 4 | Command in the address phase, byte enables (active low) in data phases |
| fifo_full | input | 1 | Inbound FIFO cannot take a word |
| devsel_n | output | 1 | Transaction claimed, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Disconnect/retry request, active low |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | IDX_W | Word index of the register written |
| reg_wr_data | output | 32 | Register write data |
| reg_wr_be | output | 4 | Register byte enables, active high |
| fifo_push | output | 1 | One-cycle FIFO push |
| fifo_data | output | 32 | Word pushed into the FIFO |

## Verification
The assertions assume an initiator that follows the bus protocol. Frame_n is raised no later than the cycle in which irdy_n completes the last data phase, and irdy_n is released once frame_n is high. They also assume fifo_full changes only while the bus is idle, because the block samples it at the address phase. The bench drives every transaction through a single task that keeps to this order, changes fifo_full only at the start of an address phase, and sweeps all sixteen commands against addresses just outside, at both edges of and inside the window. It varies wait states, burst attempts and the FIFO-full flag as it goes.

// File: rtl/optreg_pkg.sv
package optreg_pkg;

    localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;
    localparam logic [3:0] CMD_IO_WRITE  = 4'b0011;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLAIM = 2'd1,
        ST_DRAIN = 2'd2
    } tgt_state_e;

    typedef struct packed {
        logic retry;
        logic is_fifo;
    } claim_t;

    function automatic logic is_write_cmd(input logic [3:0] cmd_n);
        return (cmd_n == CMD_MEM_WRITE) || (cmd_n == CMD_IO_WRITE);
    endfunction

    function automatic logic in_window(input logic [31:0] addr,
                                       input logic [31:0] base,
                                       input logic [32:0] span);
        return ({1'b0, addr} >= {1'b0, base}) &&
               ({1'b0, addr} < ({1'b0, base} + span));
    endfunction

endpackage

// File: rtl/optreg_decode.sv
module optreg_decode
    import optreg_pkg::*;
#(
    parameter logic [31:0] BASE      = 32'h0000_1000,
    parameter int          REG_COUNT = 4,
    parameter int          FIFO_IDX  = 3,
    parameter int          IDX_W     = 2
) (
    input  logic             frame_n,
    input  logic             bus_idle,
    input  logic [31:0]      ad,
    input  logic [3:0]       cbe_n,
    input  logic             fifo_full,
    output logic             addr_hit,
    output logic [IDX_W-1:0] hit_idx,
    output claim_t           hit_claim
);
    localparam logic [32:0] SPAN = 33'(REG_COUNT) * 33'd4;

    logic [31:0] offset;

    always_comb begin
        offset            = ad - BASE;
        hit_idx           = IDX_W'(offset >> 2);
        addr_hit          = !frame_n && bus_idle && is_write_cmd(cbe_n) &&
                            in_window(ad, BASE, SPAN);
        hit_claim.is_fifo = (int'(hit_idx) == FIFO_IDX);
        hit_claim.retry   = hit_claim.is_fifo && fifo_full;
    end
endmodule

// File: rtl/optreg_seq.sv
module optreg_seq
    import optreg_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             addr_hit,
    input  logic [IDX_W-1:0] hit_idx,
    input  claim_t           hit_claim,
    output tgt_state_e       state,
    output claim_t           claim,
    output logic [IDX_W-1:0] claim_idx,
    output logic             bus_idle,
    output logic             devsel_n,
    output logic             trdy_n,
    output logic             stop_n
);
    tgt_state_e state_nx;
    logic       released;

    always_comb begin
        released = frame_n && irdy_n;
        state_nx = state;
        case (state)
            ST_IDLE:  if (addr_hit) state_nx = ST_CLAIM;
            ST_CLAIM: begin
                if (released)                     state_nx = ST_IDLE;
                else if (!irdy_n && !claim.retry) state_nx = ST_DRAIN;
            end
            ST_DRAIN: if (released) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            claim     <= '0;
            claim_idx <= '0;
            bus_idle  <= 1'b1;
        end else begin
            state    <= state_nx;
            bus_idle <= released;
            if (state == ST_IDLE && addr_hit) begin
                claim     <= hit_claim;
                claim_idx <= hit_idx;
            end
        end
    end

    always_comb begin
        devsel_n = (state == ST_IDLE);
        stop_n   = (state == ST_IDLE);
        trdy_n   = !(state == ST_CLAIM && !claim.retry);
    end

    AST_READY_IMPLIES_SELECT: assert property (@(posedge clk) disable iff (rst)
        !trdy_n |-> (!devsel_n && !stop_n)); // R3
    AST_CLAIM_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
        $fell(devsel_n) |-> $past(!frame_n)); // R2
    AST_RELEASE_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!devsel_n && frame_n && irdy_n) |=> devsel_n); // R9
endmodule

// File: rtl/optreg_wport.sv
module optreg_wport
    import optreg_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  tgt_state_e       state,
    input  claim_t           claim,
    input  logic [IDX_W-1:0] claim_idx,
    input  logic             irdy_n,
    input  logic [31:0]      ad,
    input  logic [3:0]       cbe_n,
    output logic             reg_wr_en,
    output logic [IDX_W-1:0] reg_wr_addr,
    output logic [31:0]      reg_wr_data,
    output logic [3:0]       reg_wr_be,
    output logic             fifo_push,
    output logic [31:0]      fifo_data
);
    logic xfer;

    always_comb begin
        xfer        = (state == ST_CLAIM) && !claim.retry && !irdy_n;
        reg_wr_en   = xfer && !claim.is_fifo;
        fifo_push   = xfer && claim.is_fifo;
        reg_wr_addr = claim_idx;
        reg_wr_data = ad;
        reg_wr_be   = ~cbe_n;
        fifo_data   = ad;
    end

    AST_SINGLE_WORD: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en || fifo_push) |=> !(reg_wr_en || fifo_push)); // R8
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $countones({reg_wr_en, fifo_push}) <= 1); // R6
endmodule

// File: rtl/optreg_wr_target.sv
module optreg_wr_target
    import optreg_pkg::*;
#(
    parameter logic [31:0] BASE      = 32'h0000_1000,
    parameter int          REG_COUNT = 4,
    parameter int          FIFO_IDX  = 3,
    parameter int          IDX_W     = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic [31:0]      ad,
    input  logic [3:0]       cbe_n,
    input  logic             fifo_full,
    output logic             devsel_n,
    output logic             trdy_n,
    output logic             stop_n,
    output logic             reg_wr_en,
    output logic [IDX_W-1:0] reg_wr_addr,
    output logic [31:0]      reg_wr_data,
    output logic [3:0]       reg_wr_be,
    output logic             fifo_push,
    output logic [31:0]      fifo_data
);
    logic             addr_hit;
    logic             bus_idle;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] claim_idx;
    claim_t           hit_claim;
    claim_t           claim;
    tgt_state_e       state;

    optreg_decode #(
        .BASE(BASE), .REG_COUNT(REG_COUNT), .FIFO_IDX(FIFO_IDX), .IDX_W(IDX_W)
    ) u_decode (
        .frame_n(frame_n), .bus_idle(bus_idle), .ad(ad), .cbe_n(cbe_n),
        .fifo_full(fifo_full), .addr_hit(addr_hit), .hit_idx(hit_idx),
        .hit_claim(hit_claim)
    );

    optreg_seq #(.IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
        .addr_hit(addr_hit), .hit_idx(hit_idx), .hit_claim(hit_claim),
        .state(state), .claim(claim), .claim_idx(claim_idx),
        .bus_idle(bus_idle), .devsel_n(devsel_n), .trdy_n(trdy_n),
        .stop_n(stop_n)
    );

    optreg_wport #(.IDX_W(IDX_W)) u_wport (
        .clk(clk), .rst(rst), .state(state), .claim(claim),
        .claim_idx(claim_idx), .irdy_n(irdy_n), .ad(ad), .cbe_n(cbe_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_wr_be(reg_wr_be),
        .fifo_push(fifo_push), .fifo_data(fifo_data)
    );

    AST_STROBE_IN_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en || fifo_push) |-> (!trdy_n && !irdy_n && !devsel_n)); // R4
    AST_RETRY_NO_READY: assert property (@(posedge clk) disable iff (rst)
        ($fell(devsel_n) && trdy_n) |-> !stop_n); // R7
endmodule

// File: tb/optreg_wr_target_bench.sv
module optreg_wr_target_bench;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam int NREG = 4;
    localparam int FIDX = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1, irdy_n = 1'b1, fifo_full = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        devsel_n, trdy_n, stop_n, reg_wr_en, fifo_push;
    logic [1:0]  reg_wr_addr;
    logic [31:0] reg_wr_data, fifo_data;
    logic [3:0]  reg_wr_be;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    optreg_wr_target #(.BASE(BASE), .REG_COUNT(NREG), .FIFO_IDX(FIDX)) u_optreg_wr_target (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad),
        .cbe_n(cbe_n), .fifo_full(fifo_full), .devsel_n(devsel_n),
        .trdy_n(trdy_n), .stop_n(stop_n), .reg_wr_en(reg_wr_en),
        .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_wr_be(reg_wr_be), .fifo_push(fifo_push), .fifo_data(fifo_data)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_quiet(input string tag);
        chk({reg_wr_en, fifo_push} == 2'b00, tag, {30'd0, reg_wr_en, fifo_push}, 32'd0);
    endtask

    task automatic transact(input logic [3:0] cmd, input logic [31:0] addr,
                            input logic [31:0] data, input logic [3:0] be,
                            input int waits, input bit full, input bit burst);
        bit hit, retry, xfer;
        int idx;
        hit   = (cmd == 4'b0111 || cmd == 4'b0011) && addr >= BASE && addr < BASE + 4*NREG;
        idx   = int'((addr - BASE) >> 2);
        retry = hit && full && idx == FIDX;
        xfer  = hit && !retry;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad = addr; cbe_n = cmd; fifo_full = full;
        #1 chk(devsel_n == 1'b1, "R2 no claim during address phase", 32'(devsel_n), 32'd1);
        @(negedge clk);
        ad = data; cbe_n = ~be;
        if (waits == 0) begin irdy_n = 1'b0; frame_n = !burst; end
        #1;
        chk(devsel_n == !hit, "R2/R3 devsel_n after address", 32'(devsel_n), 32'(!hit));
        chk(stop_n == !hit, "R3/R7 stop_n after address", 32'(stop_n), 32'(!hit));
        chk(trdy_n == !xfer, "R3/R7 trdy_n after address", 32'(trdy_n), 32'(!xfer));
        if (waits > 0) chk_quiet("R4 no strobe while irdy_n high");
        for (int w = 1; w <= waits; w++) begin
            @(negedge clk);
            if (w == waits) begin irdy_n = 1'b0; frame_n = !burst; end
            #1 chk(trdy_n == !xfer, "R4 trdy_n held through wait", 32'(trdy_n), 32'(!xfer));
            if (w < waits) chk_quiet("R4 no strobe in wait state");
        end
        chk(reg_wr_en == (xfer && idx != FIDX), "R5 reg_wr_en in transfer",
            32'(reg_wr_en), 32'(xfer && idx != FIDX));
        chk(fifo_push == (xfer && idx == FIDX), "R6/R7 fifo_push in transfer",
            32'(fifo_push), 32'(xfer && idx == FIDX));
        if (xfer && idx != FIDX) begin
            chk(reg_wr_addr == 2'(idx), "R5 reg_wr_addr", 32'(reg_wr_addr), 32'(idx));
            chk(reg_wr_data == data, "R5 reg_wr_data", reg_wr_data, data);
            chk(reg_wr_be == be, "R5 reg_wr_be", 32'(reg_wr_be), 32'(be));
        end
        if (xfer && idx == FIDX)
            chk(fifo_data == data, "R6 fifo_data", fifo_data, data);
        if (burst) begin
            @(negedge clk);
            ad = ~data; frame_n = 1'b0; irdy_n = 1'b0;
            #1 chk_quiet("R8 no strobe on burst attempt");
            chk(trdy_n == 1'b1, "R8 trdy_n released on burst", 32'(trdy_n), 32'd1);
            chk(stop_n == !hit, "R8 stop_n held on burst", 32'(stop_n), 32'(!hit));
            @(negedge clk);
            frame_n = 1'b1; irdy_n = 1'b0;
            #1 chk_quiet("R8 no strobe on last burst phase");
        end
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b1;
        #1 chk(stop_n == !hit, "R8 stop_n held until release", 32'(stop_n), 32'(!hit));
        chk(trdy_n == 1'b1, "R8 trdy_n after transfer", 32'(trdy_n), 32'd1);
        chk_quiet("R8 no second strobe");
        @(negedge clk);
        #1 chk({devsel_n, trdy_n, stop_n} == 3'b111, "R9 released after idle",
               32'({devsel_n, trdy_n, stop_n}), 32'd7);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R9 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 chk({devsel_n, trdy_n, stop_n, reg_wr_en, fifo_push} == 5'b11100,
               "R1 reset outputs", 32'({devsel_n, trdy_n, stop_n, reg_wr_en, fifo_push}), 32'h1C);
        rst = 1'b0;
        @(negedge clk);
        #1 chk({devsel_n, trdy_n, stop_n, reg_wr_en, fifo_push} == 5'b11100,
               "R1 first cycle after reset", 32'({devsel_n, trdy_n, stop_n, reg_wr_en, fifo_push}), 32'h1C);

        for (int c = 0; c < 16; c++) begin
            for (int a = 0; a < 6; a++) begin
                for (int f = 0; f < 2; f++) begin
                    logic [31:0] addr, data;
                    addr = BASE - 32'd4 + 32'(a) * 32'd4;
                    data = 32'hA500_0000 + 32'(c) * 32'h0001_0203 + 32'(a * 7 + f);
                    transact(4'(c), addr, data, 4'((c + a + f) % 16),
                             (c + a + f) % 3, f[0], a[0] ^ f[0]);
                end
            end
        end

        // R7: full FIFO only blocks the FIFO slot; retry then succeed
        transact(4'b0111, BASE + 32'd12, 32'hDEAD_0001, 4'hF, 0, 1'b1, 1'b0);
        transact(4'b0111, BASE + 32'd12, 32'hDEAD_0002, 4'hF, 0, 1'b0, 1'b0);
        transact(4'b0011, BASE + 32'd4, 32'hDEAD_0003, 4'h5, 1, 1'b1, 1'b0);

        // R10: write-like pattern inside another device's transaction
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad = BASE + 32'h100; cbe_n = 4'b0110; fifo_full = 1'b0;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b0; ad = BASE; cbe_n = 4'b0111;
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b0;
        #1 chk(devsel_n == 1'b1, "R10 mid-transaction pattern ignored", 32'(devsel_n), 32'd1);
        chk_quiet("R10 no strobe from foreign transaction");
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b1;
        #1 chk(devsel_n == 1'b1, "R10 still unclaimed", 32'(devsel_n), 32'd1);
        transact(4'b0111, BASE + 32'd8, 32'h1234_5678, 4'h3, 0, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule